// File: doc/BRIEF.md
# Priority Chip-Select Decoder

This block turns a 16-bit address into a set of chip selects for four kinds of target: an SRAM, an I/O region, four secondary (boot) flash sectors and four main flash sectors. Each target is described by one or more address windows. A window is a 16-bit match value, a 16-bit care mask and an enable bit, and all of them are loaded through a small synchronous write port. The SRAM select is the OR of three separate windows, so that scattered regions can be mapped to it.

Windows of different kinds may overlap, and a fixed three-level priority settles which target wins. SRAM and I/O rank highest, the boot sectors come next, and the main sectors rank lowest. The selects are combinational from the address. They are always one-hot or all-zero, and a separate flag marks an address that hits nothing.

A configuration checker looks at the loaded windows and raises an error flag in two cases: two windows of the same level overlap, or a sector window covers more space than a physical sector holds. The flag reports only. Decoding carries on unchanged while it is set.

Top module: `prio_cs_decoder`

## Requirements
- R1: A write with `wrEn` high is stored on the rising clock edge. `wrAddr[5:2]` selects the window: 0-3 are main sectors 0-3, 4-7 are boot sectors 0-3, 8-10 are SRAM terms 0-2 and 11 is the I/O window. `wrAddr[1:0]` selects the field: 0 is the match value, 1 is the care mask, and 2 is the enable, taken from `wrData[0]`. A write to window index 12-15, or to field 3, changes nothing.
- R2: After reset every window is disabled and its value and mask are zero. No select is asserted, `noHit` is 1 and `cfgErr` is 0.
- R3: An enabled window hits when `((addr ^ value) & mask) == 0`. A mask bit of 1 means the bit is compared. A disabled window never hits.
- R4: `csSram` is asserted when any of the three SRAM terms hits.
- R5: An address that hits the SRAM or the I/O window asserts that select, and no boot or main sector is selected.
- R6: An address that hits a boot sector, and no SRAM or I/O window, selects the boot sector even when it also hits a main sector.
- R7: At most one select among `csMain`, `csBoot`, `csSram` and `csIo` is high at any time. If windows of one level overlap in error, the lowest-indexed sector of that level wins, and SRAM wins over I/O.
- R8: `noHit` is 1 exactly when no select is asserted.
- R9: `cfgErr` is 1 when two enabled main sectors overlap, when two enabled boot sectors overlap, or when an enabled SRAM term overlaps the enabled I/O window. Two windows overlap when `((v1 ^ v2) & m1 & m2) == 0`. Overlaps between SRAM terms are allowed.
- R10: `cfgErr` is 1 when an enabled main window has more than 14 zero mask bits (larger than 16 KiB), or when an enabled boot window has more than 13 (larger than 8 KiB). A window of exactly sector size is legal, and disabled windows are not checked.
- R11: `cfgErr` does not gate the selects. Decoding follows R3-R8 whatever the value of the flag.
- R12: With main sector 0 at 8000h-BFFFh, boot sector 0 at 8000h-9FFFh and SRAM term 0 at 8000h-87FFh, the decoder selects SRAM for 8000h-87FFh, boot sector 0 for 8800h-9FFFh and main sector 0 for A000h-BFFFh. `cfgErr` stays 0.
- R13: The selects and `noHit` follow a change of `addr` in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the window registers |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for the window registers |
| wrAddr | input | 6 | Window index in bits 5:2, field in bits 1:0 |
| wrData | input | 16 | Write data; bit 0 alone for the enable field |
| addr | input | 16 | Address to decode |
| csMain | output | 4 | Main flash sector selects |
| csBoot | output | 4 | Boot flash sector selects |
| csSram | output | 1 | SRAM select |
| csIo | output | 1 | I/O select |
| noHit | output | 1 | High when the address selects no target |
| cfgErr | output | 1 | Configuration error: same-level overlap or oversized sector |

## Verification
The assertions check four things on every cycle. The selects are one-hot or zero. `noHit` agrees with the selects. The error flag changes only after a write. The outputs hold while the address is stable and the last write was idle or aimed at an unused index or field. The bench scenarios are the only place to show which target wins an overlap, the exact size limits, the OR of the SRAM terms, that the error flag leaves decoding alone, and the worked three-window map. The bench compares each of these with a reference model and with literal expected values.

// File: rtl/prio_cs_pkg.sv
package prio_cs_pkg;
  localparam int CS_ADDR_W    = 16;
  localparam int CS_NUM_MAIN  = 4;
  localparam int CS_NUM_BOOT  = 4;
  localparam int CS_NUM_RAM   = 3;
  localparam int CS_NUM_WIN   = CS_NUM_MAIN + CS_NUM_BOOT + CS_NUM_RAM + 1;
  localparam int CS_MAIN_BASE = 0;
  localparam int CS_BOOT_BASE = CS_MAIN_BASE + CS_NUM_MAIN;
  localparam int CS_RAM_BASE  = CS_BOOT_BASE + CS_NUM_BOOT;
  localparam int CS_IO_IDX    = CS_RAM_BASE + CS_NUM_RAM;
  localparam int CS_IDX_W     = $clog2(CS_NUM_WIN);
  localparam int CS_FLD_W     = 2;
  localparam int CS_WADDR_W   = CS_IDX_W + CS_FLD_W;

  typedef enum logic [CS_FLD_W-1:0] {
    FLD_VALUE  = 2'd0,
    FLD_MASK   = 2'd1,
    FLD_ENABLE = 2'd2,
    FLD_RSVD   = 2'd3
  } winField_e;

  // Register load strobes passed from control to datapath
  typedef struct packed {
    logic [CS_NUM_WIN-1:0] ldValue;
    logic [CS_NUM_WIN-1:0] ldMask;
    logic [CS_NUM_WIN-1:0] ldEnable;
    logic [CS_ADDR_W-1:0]  data;
  } regStrobes_t;
endpackage

// File: rtl/prio_cs_ctrl.sv
module prio_cs_ctrl
  import prio_cs_pkg::*;
(
  input  logic                  wrEn,
  input  logic [CS_WADDR_W-1:0] wrAddr,
  input  logic [CS_ADDR_W-1:0]  wrData,
  output regStrobes_t           strobes
);
  localparam logic [CS_IDX_W-1:0] LAST_IDX = CS_IDX_W'(CS_NUM_WIN - 1);

  logic [CS_IDX_W-1:0] winIdx;
  logic [CS_FLD_W-1:0] winFld;

  assign winIdx = wrAddr[CS_WADDR_W-1:CS_FLD_W];
  assign winFld = wrAddr[CS_FLD_W-1:0];

  always_comb begin
    strobes      = '0;
    strobes.data = wrData;
    if (wrEn && (winIdx <= LAST_IDX)) begin
      case (winFld)
        FLD_VALUE:  strobes.ldValue[winIdx]  = 1'b1;
        FLD_MASK:   strobes.ldMask[winIdx]   = 1'b1;
        FLD_ENABLE: strobes.ldEnable[winIdx] = 1'b1;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/prio_cs_datapath.sv
module prio_cs_datapath
  import prio_cs_pkg::*;
(
  input  logic                                 clk,
  input  logic                                 rstN,
  input  regStrobes_t                          strobes,
  input  logic [CS_ADDR_W-1:0]                 addr,
  output logic [CS_NUM_WIN-1:0][CS_ADDR_W-1:0] winValue,
  output logic [CS_NUM_WIN-1:0][CS_ADDR_W-1:0] winMask,
  output logic [CS_NUM_WIN-1:0]                winEn,
  output logic [CS_NUM_MAIN-1:0]               csMain,
  output logic [CS_NUM_BOOT-1:0]               csBoot,
  output logic                                 csSram,
  output logic                                 csIo,
  output logic                                 noHit
);
  logic [CS_NUM_WIN-1:0]  rawHit;
  logic [CS_NUM_MAIN-1:0] mainRaw, mainPick;
  logic [CS_NUM_BOOT-1:0] bootRaw, bootPick;
  logic                   ramAny, ioRaw, levelOne, bootAny;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winValue <= '0;
      winMask  <= '0;
      winEn    <= '0;
    end else begin
      for (int w = 0; w < CS_NUM_WIN; w++) begin
        if (strobes.ldValue[w])  winValue[w] <= strobes.data;
        if (strobes.ldMask[w])   winMask[w]  <= strobes.data;
        if (strobes.ldEnable[w]) winEn[w]    <= strobes.data[0];
      end
    end
  end

  always_comb begin
    for (int w = 0; w < CS_NUM_WIN; w++)
      rawHit[w] = winEn[w] && (((addr ^ winValue[w]) & winMask[w]) == '0);
  end

  assign mainRaw = rawHit[CS_MAIN_BASE +: CS_NUM_MAIN];
  assign bootRaw = rawHit[CS_BOOT_BASE +: CS_NUM_BOOT];
  assign ramAny  = |rawHit[CS_RAM_BASE +: CS_NUM_RAM];
  assign ioRaw   = rawHit[CS_IO_IDX];

  // lowest-index survivor inside a level
  assign mainPick = mainRaw & (~mainRaw + CS_NUM_MAIN'(1));
  assign bootPick = bootRaw & (~bootRaw + CS_NUM_BOOT'(1));

  assign levelOne = ramAny | ioRaw;
  assign bootAny  = |bootRaw;

  assign csSram = ramAny;
  assign csIo   = ioRaw & ~ramAny;
  assign csBoot = levelOne ? '0 : bootPick;
  assign csMain = (levelOne | bootAny) ? '0 : mainPick;
  assign noHit  = ~(levelOne | bootAny | (|mainRaw));
endmodule

// File: rtl/prio_cs_cfgchk.sv
module prio_cs_cfgchk
  import prio_cs_pkg::*;
#(
  parameter int MAIN_SECT_LOG2 = 14,
  parameter int BOOT_SECT_LOG2 = 13
) (
  input  logic [CS_NUM_WIN-1:0][CS_ADDR_W-1:0] winValue,
  input  logic [CS_NUM_WIN-1:0][CS_ADDR_W-1:0] winMask,
  input  logic [CS_NUM_WIN-1:0]                winEn,
  output logic                                 cfgErr
);
  function automatic logic windowsMeet(input logic [CS_ADDR_W-1:0] v1, m1, v2, m2);
    return ((v1 ^ v2) & m1 & m2) == '0;
  endfunction

  function automatic int freeBits(input logic [CS_ADDR_W-1:0] m);
    int n = 0;
    for (int b = 0; b < CS_ADDR_W; b++) if (!m[b]) n++;
    return n;
  endfunction

  logic overlapErr, sizeErr;

  always_comb begin
    overlapErr = 1'b0;
    for (int i = 0; i < CS_NUM_MAIN; i++)
      for (int j = i + 1; j < CS_NUM_MAIN; j++)
        if (winEn[CS_MAIN_BASE+i] && winEn[CS_MAIN_BASE+j] &&
            windowsMeet(winValue[CS_MAIN_BASE+i], winMask[CS_MAIN_BASE+i],
                        winValue[CS_MAIN_BASE+j], winMask[CS_MAIN_BASE+j]))
          overlapErr = 1'b1;
    for (int i = 0; i < CS_NUM_BOOT; i++)
      for (int j = i + 1; j < CS_NUM_BOOT; j++)
        if (winEn[CS_BOOT_BASE+i] && winEn[CS_BOOT_BASE+j] &&
            windowsMeet(winValue[CS_BOOT_BASE+i], winMask[CS_BOOT_BASE+i],
                        winValue[CS_BOOT_BASE+j], winMask[CS_BOOT_BASE+j]))
          overlapErr = 1'b1;
    for (int t = 0; t < CS_NUM_RAM; t++)
      if (winEn[CS_RAM_BASE+t] && winEn[CS_IO_IDX] &&
          windowsMeet(winValue[CS_RAM_BASE+t], winMask[CS_RAM_BASE+t],
                      winValue[CS_IO_IDX], winMask[CS_IO_IDX]))
        overlapErr = 1'b1;
  end

  always_comb begin
    sizeErr = 1'b0;
    for (int i = 0; i < CS_NUM_MAIN; i++)
      if (winEn[CS_MAIN_BASE+i] && (freeBits(winMask[CS_MAIN_BASE+i]) > MAIN_SECT_LOG2))
        sizeErr = 1'b1;
    for (int i = 0; i < CS_NUM_BOOT; i++)
      if (winEn[CS_BOOT_BASE+i] && (freeBits(winMask[CS_BOOT_BASE+i]) > BOOT_SECT_LOG2))
        sizeErr = 1'b1;
  end

  assign cfgErr = overlapErr | sizeErr;
endmodule

// File: rtl/prio_cs_decoder.sv
module prio_cs_decoder
  import prio_cs_pkg::*;
#(
  parameter int MAIN_SECT_LOG2 = 14,
  parameter int BOOT_SECT_LOG2 = 13
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [CS_WADDR_W-1:0]  wrAddr,
  input  logic [CS_ADDR_W-1:0]   wrData,
  input  logic [CS_ADDR_W-1:0]   addr,
  output logic [CS_NUM_MAIN-1:0] csMain,
  output logic [CS_NUM_BOOT-1:0] csBoot,
  output logic                   csSram,
  output logic                   csIo,
  output logic                   noHit,
  output logic                   cfgErr
);
  regStrobes_t                          strobes;
  logic [CS_NUM_WIN-1:0][CS_ADDR_W-1:0] winValue;
  logic [CS_NUM_WIN-1:0][CS_ADDR_W-1:0] winMask;
  logic [CS_NUM_WIN-1:0]                winEn;

  prio_cs_ctrl ctrl_i (
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .strobes (strobes)
  );

  prio_cs_datapath dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .addr     (addr),
    .winValue (winValue),
    .winMask  (winMask),
    .winEn    (winEn),
    .csMain   (csMain),
    .csBoot   (csBoot),
    .csSram   (csSram),
    .csIo     (csIo),
    .noHit    (noHit)
  );

  prio_cs_cfgchk #(
    .MAIN_SECT_LOG2 (MAIN_SECT_LOG2),
    .BOOT_SECT_LOG2 (BOOT_SECT_LOG2)
  ) chk_cfg_i (
    .winValue (winValue),
    .winMask  (winMask),
    .winEn    (winEn),
    .cfgErr   (cfgErr)
  );
endmodule

// File: rtl/prio_cs_decoder_chk.sv
module prio_cs_decoder_chk
  import prio_cs_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   wrEn,
  input logic [CS_WADDR_W-1:0]  wrAddr,
  input logic [CS_ADDR_W-1:0]   addr,
  input logic [CS_NUM_MAIN-1:0] csMain,
  input logic [CS_NUM_BOOT-1:0] csBoot,
  input logic                   csSram,
  input logic                   csIo,
  input logic                   noHit,
  input logic                   cfgErr
);
  localparam logic [CS_IDX_W-1:0] LAST_IDX = CS_IDX_W'(CS_NUM_WIN - 1);

  logic [CS_NUM_MAIN+CS_NUM_BOOT+1:0] allSel;
  assign allSel = {csMain, csBoot, csSram, csIo};

  // R7: never two selects at once
  a_r7_sel_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(allSel));

  // R8: no-hit flag agrees with the selects
  a_r8_nohit_match: assert property (@(posedge clk) disable iff (!rstN)
    noHit == (allSel == '0));

  // R9 / R10: the error flag moves only after a write
  a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wrEn) |-> $stable(cfgErr));

  // R1: an idle or ignored write leaves decoding unchanged for a steady address
  a_r1_ignored_write: assert property (@(posedge clk) disable iff (!rstN)
    ((!$past(wrEn) || ($past(wrAddr[CS_WADDR_W-1:CS_FLD_W]) > LAST_IDX) ||
      ($past(wrAddr[CS_FLD_W-1:0]) == FLD_RSVD)) && $stable(addr))
    |-> $stable({allSel, noHit, cfgErr}));
endmodule

bind prio_cs_decoder prio_cs_decoder_chk chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .wrAddr (wrAddr),
  .addr   (addr),
  .csMain (csMain),
  .csBoot (csBoot),
  .csSram (csSram),
  .csIo   (csIo),
  .noHit  (noHit),
  .cfgErr (cfgErr)
);

// File: tb/prio_cs_decoder_tb_top.sv
`timescale 1ns/1ps
module prio_cs_decoder_tb_top;
  import prio_cs_pkg::*;

  localparam int MAIN_LOG2 = 14;
  localparam int BOOT_LOG2 = 13;
  localparam int WATCHDOG_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [5:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] addr = '0;
  logic [3:0]  csMain, csBoot;
  logic        csSram, csIo, noHit, cfgErr;
  logic [10:0] dutSel;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [15:0] mVal [CS_NUM_WIN];
  logic [15:0] mMsk [CS_NUM_WIN];
  logic        mEn  [CS_NUM_WIN];

  always #5 clk = ~clk;

  prio_cs_decoder dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .addr(addr), .csMain(csMain), .csBoot(csBoot), .csSram(csSram),
    .csIo(csIo), .noHit(noHit), .cfgErr(cfgErr)
  );

  // layout {main[3:0], boot[3:0], sram, io, noHit}
  assign dutSel = {csMain, csBoot, csSram, csIo, noHit};

  function automatic logic hitOf(int w, logic [15:0] a);
    return mEn[w] && (((a ^ mVal[w]) & mMsk[w]) == 16'h0);
  endfunction

  function automatic logic [10:0] expSel(logic [15:0] a);
    logic ram = 1'b0;
    for (int t = 0; t < CS_NUM_RAM; t++) if (hitOf(CS_RAM_BASE + t, a)) ram = 1'b1;
    if (ram) return 11'h004;
    if (hitOf(CS_IO_IDX, a)) return 11'h002;
    for (int b = 0; b < CS_NUM_BOOT; b++) if (hitOf(CS_BOOT_BASE + b, a)) return 11'(1 << (3 + b));
    for (int m = 0; m < CS_NUM_MAIN; m++) if (hitOf(CS_MAIN_BASE + m, a)) return 11'(1 << (7 + m));
    return 11'h001;
  endfunction

  function automatic logic meet(int x, int y);
    return mEn[x] && mEn[y] && (((mVal[x] ^ mVal[y]) & mMsk[x] & mMsk[y]) == 16'h0);
  endfunction

  function automatic int zeros(logic [15:0] m);
    int n = 0;
    for (int b = 0; b < 16; b++) if (!m[b]) n++;
    return n;
  endfunction

  function automatic logic expErr();
    logic e = 1'b0;
    for (int i = 0; i < CS_NUM_MAIN; i++) begin
      for (int j = i + 1; j < CS_NUM_MAIN; j++) if (meet(CS_MAIN_BASE + i, CS_MAIN_BASE + j)) e = 1'b1;
      if (mEn[CS_MAIN_BASE + i] && zeros(mMsk[CS_MAIN_BASE + i]) > MAIN_LOG2) e = 1'b1;
    end
    for (int i = 0; i < CS_NUM_BOOT; i++) begin
      for (int j = i + 1; j < CS_NUM_BOOT; j++) if (meet(CS_BOOT_BASE + i, CS_BOOT_BASE + j)) e = 1'b1;
      if (mEn[CS_BOOT_BASE + i] && zeros(mMsk[CS_BOOT_BASE + i]) > BOOT_LOG2) e = 1'b1;
    end
    for (int t = 0; t < CS_NUM_RAM; t++) if (meet(CS_RAM_BASE + t, CS_IO_IDX)) e = 1'b1;
    return e;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input int fld, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = {4'(idx), 2'(fld)}; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    if (idx < CS_NUM_WIN) begin
      if (fld == 0) mVal[idx] = d;
      else if (fld == 1) mMsk[idx] = d;
      else if (fld == 2) mEn[idx] = d[0];
    end
  endtask

  task automatic setWin(input int idx, input logic [15:0] v, input logic [15:0] m, input logic en);
    wr(idx, 0, v);
    wr(idx, 1, m);
    wr(idx, 2, {15'h0, en});
  endtask

  // literal expectation, cross-checked against the model as well
  task automatic probe(input string req, input logic [15:0] a, input logic [10:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    chk(req, {21'h0, dutSel}, {21'h0, exp});
    chk({req, " model"}, {21'h0, dutSel}, {21'h0, expSel(a)});
  endtask

  task automatic probeModel(input string req, input logic [15:0] a);
    @(negedge clk);
    addr = a;
    #1;
    chk(req, {21'h0, dutSel}, {21'h0, expSel(a)});
  endtask

  task automatic chkErr(input string req, input logic exp);
    #1;
    chk(req, {31'h0, cfgErr}, {31'h0, exp});
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1c0de5));
    for (int w = 0; w < CS_NUM_WIN; w++) begin mVal[w] = '0; mMsk[w] = '0; mEn[w] = 1'b0; end
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R2 reset state
    probe("R2 reset 0000", 16'h0000, 11'h001);
    probe("R2 reset ffff", 16'hFFFF, 11'h001);
    chkErr("R2 reset cfgErr", 1'b0);

    // R12 worked map, R5 R6 R3 R13
    setWin(CS_MAIN_BASE, 16'h8000, 16'hC000, 1'b1);
    setWin(CS_BOOT_BASE, 16'h8000, 16'hE000, 1'b1);
    setWin(CS_RAM_BASE, 16'h8000, 16'hF800, 1'b1);
    chkErr("R12 map legal", 1'b0);
    probe("R12 R5 8000", 16'h8000, 11'h004);
    probe("R12 R5 87ff", 16'h87FF, 11'h004);
    probe("R12 R6 8800", 16'h8800, 11'h008);
    probe("R12 R6 9fff", 16'h9FFF, 11'h008);
    probe("R12 R3 a000", 16'hA000, 11'h080);
    probe("R12 R13 bfff", 16'hBFFF, 11'h080);
    probe("R12 R3 c000", 16'hC000, 11'h001);

    // R4 SRAM terms ORed
    setWin(CS_RAM_BASE + 1, 16'h0000, 16'hFF00, 1'b1);
    setWin(CS_RAM_BASE + 2, 16'h1000, 16'hFF00, 1'b1);
    probe("R4 term1", 16'h0010, 11'h004);
    probe("R4 term2", 16'h1010, 11'h004);
    probe("R4 gap", 16'h2000, 11'h001);
    chkErr("R9 sram terms may overlap", 1'b0);

    // I/O window
    setWin(CS_IO_IDX, 16'h4000, 16'hFF00, 1'b1);
    probe("R3 io hit", 16'h4050, 11'h002);
    probe("R3 io miss", 16'h4100, 11'h001);

    // R10 oversize main, R11 no gating
    setWin(CS_MAIN_BASE + 1, 16'h0000, 16'h8000, 1'b1);
    chkErr("R10 main oversize", 1'b1);
    probe("R11 decode under error", 16'h3000, 11'h100);
    probe("R5 sram over main", 16'h0010, 11'h004);
    wr(CS_MAIN_BASE + 1, 1, 16'hC000);
    chkErr("R10 main exact size", 1'b0);

    // R10 oversize boot, R6 boot over main
    setWin(CS_BOOT_BASE + 1, 16'h0000, 16'hC000, 1'b1);
    chkErr("R10 boot oversize", 1'b1);
    probe("R6 boot over main", 16'h3000, 11'h010);
    wr(CS_BOOT_BASE + 1, 2, 16'h0000);
    chkErr("R10 disabled boot ignored", 1'b0);
    probe("R3 disabled window", 16'h3000, 11'h100);

    // R9 / R7 same-level overlaps
    setWin(CS_IO_IDX, 16'h0000, 16'hFF00, 1'b1);
    chkErr("R9 sram io overlap", 1'b1);
    probe("R7 sram over io", 16'h0005, 11'h004);
    wr(CS_IO_IDX, 0, 16'h4000);
    chkErr("R9 io moved away", 1'b0);
    setWin(CS_BOOT_BASE + 2, 16'hC000, 16'hE000, 1'b1);
    setWin(CS_BOOT_BASE + 3, 16'hC000, 16'hF000, 1'b1);
    chkErr("R9 boot overlap", 1'b1);
    probe("R7 lowest boot wins", 16'hC100, 11'h020);
    setWin(CS_MAIN_BASE + 2, 16'hA000, 16'hE000, 1'b1);
    wr(CS_BOOT_BASE + 3, 2, 16'h0000);
    chkErr("R9 main overlap", 1'b1);
    probe("R7 lowest main wins", 16'hA100, 11'h080);
    wr(CS_MAIN_BASE + 2, 2, 16'h0000);
    wr(CS_BOOT_BASE + 3, 1, 16'h0000);
    chkErr("R10 disabled oversize ignored", 1'b0);

    // R1 ignored writes
    wr(12, 0, 16'hFFFF);
    wr(12, 2, 16'hFFFF);
    wr(0, 3, 16'hFFFF);
    chkErr("R1 ignored write cfg", 1'b0);
    probe("R1 ignored write main0", 16'hA000, 11'h080);
    probe("R1 ignored write miss", 16'hE000, 11'h001);

    // constrained random configurations
    for (int c = 0; c < 40; c++) begin
      for (int w = 0; w < CS_NUM_WIN; w++) begin
        int care;
        logic [15:0] msk;
        care = 11 + int'($urandom % 6);
        msk = 16'hFFFF << (16 - care);
        if (($urandom % 8) == 0) msk = 16'($urandom);
        setWin(w, 16'($urandom), msk, 1'($urandom % 2));
      end
      chkErr("R9 R10 random cfgErr", expErr());
      for (int k = 0; k < 50; k++) begin
        int w;
        logic [15:0] a;
        w = int'($urandom % CS_NUM_WIN);
        a = 16'($urandom);
        if (k % 2 == 0) a = mVal[w] ^ (a & ~mMsk[w]);
        probeModel("R7 R11 random decode", a);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule